// File: doc/BRIEF.md
# Fixed Pointer Overhead Generator with Alarm Forcing

This block supplies the nine pointer bytes of row four of an STS-3c/STM-1 transmit frame (three H1, three H2 and three H3 positions). The payload is built in lock-step with the overhead, so the pointer never moves. The first H1/H2 pair always carries the offset 522. The other two pairs carry the concatenation indication. The three H3 bytes idle at zero.

Two alarm requests, one for the line and one for the path, force all nine bytes to all ones. The requests are sampled only on the frame-start marker, so a frame never mixes alarm and normal bytes. When both requests have dropped, the next frame carries the New Data Flag enabled in the first H1 byte. Every frame after that carries it disabled. Reset counts as an alarm that has just cleared.

The frame assembler pulses the frame-start input, then presents a slot index with a valid strobe for each pointer position. One clock later the block returns the byte to insert at that position.

Top module: `ptr_ais_gen`

## Requirements
- R1: After reset `out_valid` is 0. The first frame whose start sees no alarm request carries the enabled flag: slot 0 reads 0x92.
- R2: In a normal frame without the flag, slot 0 (first H1) reads 0x62 and slot 3 (first H2) reads 0x0A. These bytes are the flag nibble 0110, size bits 00 and the 10-bit offset 522.
- R3: Slots 1 and 2 (concatenated H1) read 0x93, and slots 4 and 5 (concatenated H2) read 0xFF, in normal and flag frames alike.
- R4: Slots 6, 7 and 8 (H3) read 0x00 in every frame that is not forced.
- R5: When either alarm request is 1 at a frame start, all nine slots of that frame read 0xFF.
- R6: The flag nibble 1001 appears in slot 0 (giving 0x92) only in the first frame whose start sees both requests at 0 after a frame that was forced. It appears in no later frame.
- R7: A change of the alarm requests between frame starts has no effect on the bytes until the next frame start. A slot presented in the same cycle as `frame_start` already belongs to the new frame.
- R8: `out_byte` and `out_valid` follow a slot request after exactly one clock. A slot index of 9 or more gives `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle marker at the start of each frame |
| slot_valid | input | 1 | A pointer slot is requested this cycle |
| slot_idx | input | 4 | Slot: 0-2 H1, 3-5 H2, 6-8 H3 |
| line_ais_req | input | 1 | Line alarm indication request |
| path_ais_req | input | 1 | Path alarm indication request |
| out_valid | output | 1 | `out_byte` is valid |
| out_byte | output | 8 | Pointer byte for the requested slot |

## Verification
A wrong alarm state bit shows in the first slot requested after the faulty frame start, as all ones where a normal byte is expected, or the reverse. A wrong flag bit shows only in slot 0: a flag frame missing after an alarm, or a flag repeated in a second frame. Such an error can therefore hide until the next slot 0, one frame later. The bench requests every slot of every frame and runs alarm patterns that toggle from frame to frame, so every state bit reaches the outputs within one frame.

// File: rtl/ptr_ais_pkg.sv
package ptr_ais_pkg;

    localparam int BYTE_W = 8;
    localparam int SLOTS  = 9;
    localparam int IDX_W  = 4;
    localparam int PTR_W  = 10;

    typedef logic [BYTE_W-1:0] byte_t;

    // Frame-level state, fixed for the whole frame at its start
    typedef struct packed {
        logic ais;   // frame is forced to all ones
        logic ndf;   // frame carries the enabled new-data flag
    } frame_t;

    typedef enum logic [1:0] {
        KIND_H1 = 2'd0,
        KIND_H2 = 2'd1,
        KIND_H3 = 2'd2
    } slot_kind_e;

    localparam byte_t CONCAT_H1 = 8'h93;
    localparam byte_t CONCAT_H2 = 8'hFF;
    localparam byte_t H3_IDLE   = 8'h00;
    localparam byte_t AIS_BYTE  = 8'hFF;

    function automatic byte_t make_h1(input logic [3:0] flag,
                                      input logic [1:0] size_bits,
                                      input logic [PTR_W-1:0] ptr);
        return {flag, size_bits, ptr[PTR_W-1:PTR_W-2]};
    endfunction

    function automatic byte_t make_h2(input logic [PTR_W-1:0] ptr);
        return ptr[BYTE_W-1:0];
    endfunction

    function automatic slot_kind_e kind_of(input int s);
        return slot_kind_e'(s / 3);
    endfunction

endpackage

// File: rtl/ptr_frame_state.sv
module ptr_frame_state
    import ptr_ais_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_start,
    input  logic   ais_req,
    output frame_t frame_next,
    output frame_t frame_q
);
    always_comb begin
        frame_next = frame_q;
        if (frame_start) begin
            frame_next.ais = ais_req;
            frame_next.ndf = frame_q.ais & ~ais_req;
        end
    end

    // Reset acts as an alarm that is about to clear
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q.ais <= 1'b1;
            frame_q.ndf <= 1'b0;
        end else begin
            frame_q <= frame_next;
        end
    end
endmodule

// File: rtl/ptr_byte_sel.sv
module ptr_byte_sel
    import ptr_ais_pkg::*;
#(
    parameter logic [PTR_W-1:0] PTR_VALUE = 10'd522,
    parameter logic [3:0]       NDF_ON    = 4'b1001,
    parameter logic [3:0]       NDF_OFF   = 4'b0110,
    parameter logic [1:0]       SIZE_BITS = 2'b00
) (
    input  logic [IDX_W-1:0] slot_idx,
    input  frame_t           frame,
    output logic             in_range,
    output byte_t            byte_out
);
    localparam byte_t H1_ON = make_h1(NDF_ON, SIZE_BITS, PTR_VALUE);

    byte_t normal [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (kind_of(s) == KIND_H1) begin : g_h1
            if (s % 3 == 0) begin : g_first
                assign normal[s] = make_h1(NDF_OFF, SIZE_BITS, PTR_VALUE);
            end else begin : g_cat
                assign normal[s] = CONCAT_H1;
            end
        end else if (kind_of(s) == KIND_H2) begin : g_h2
            if (s % 3 == 0) begin : g_first
                assign normal[s] = make_h2(PTR_VALUE);
            end else begin : g_cat
                assign normal[s] = CONCAT_H2;
            end
        end else begin : g_h3
            assign normal[s] = H3_IDLE;
        end
    end

    always_comb begin
        in_range = (slot_idx < IDX_W'(SLOTS));
        byte_out = '0;
        if (in_range) begin
            if (frame.ais)
                byte_out = AIS_BYTE;
            else if (frame.ndf && slot_idx == '0)
                byte_out = H1_ON;
            else
                byte_out = normal[slot_idx];
        end
    end
endmodule

// File: rtl/ptr_ais_gen.sv
module ptr_ais_gen
    import ptr_ais_pkg::*;
#(
    parameter logic [PTR_W-1:0] PTR_VALUE = 10'd522
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             slot_valid,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic             line_ais_req,
    input  logic             path_ais_req,
    output logic             out_valid,
    output logic [7:0]       out_byte
);
    frame_t frame_next;
    frame_t frame_q;
    logic   in_range;
    byte_t  sel_byte;

    ptr_frame_state u_state (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .ais_req    (line_ais_req | path_ais_req),
        .frame_next (frame_next),
        .frame_q    (frame_q)
    );

    ptr_byte_sel #(.PTR_VALUE(PTR_VALUE)) u_sel (
        .slot_idx(slot_idx),
        .frame   (frame_next),
        .in_range(in_range),
        .byte_out(sel_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= slot_valid & in_range;
            out_byte  <= sel_byte;
        end
    end
endmodule

// File: rtl/ptr_ais_gen_chk.sv
module ptr_ais_gen_chk
    import ptr_ais_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frame_start,
    input logic             slot_valid,
    input logic [IDX_W-1:0] slot_idx,
    input logic             out_valid,
    input logic [7:0]       out_byte,
    input frame_t           frame_q
);
    // R5
    ais_force_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && frame_q.ais |-> out_byte == 8'hFF);

    // R6
    ndf_once_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start && frame_q.ndf |=> !frame_q.ndf);

    // R6
    ndf_excl_chk: assert property (@(posedge clk) disable iff (rst)
        frame_q.ndf |-> !frame_q.ais);

    // R7
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(frame_q));

    // R4
    h3_zero_chk: assert property (@(posedge clk) disable iff (rst)
        slot_valid && slot_idx >= 4'd6 && slot_idx <= 4'd8 && !frame_start && !frame_q.ais
        |=> out_valid && out_byte == 8'h00);

    // R8
    range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_valid && slot_idx >= 4'd9 |=> !out_valid);
endmodule

bind ptr_ais_gen ptr_ais_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .slot_valid (slot_valid),
    .slot_idx   (slot_idx),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .frame_q    (frame_q)
);

// File: tb/ptr_ais_gen_bench.sv
module ptr_ais_gen_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       frame_start;
    logic       slot_valid;
    logic [3:0] slot_idx;
    logic       line_ais_req;
    logic       path_ais_req;
    logic       out_valid;
    logic [7:0] out_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_ais;
    bit exp_ndf;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptr_ais_gen u_ptr_ais_gen (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .slot_valid(slot_valid), .slot_idx(slot_idx),
        .line_ais_req(line_ais_req), .path_ais_req(path_ais_req),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    function automatic logic [7:0] exp_byte(input int idx, input bit ais, input bit ndf);
        if (ais) return 8'hFF;
        case (idx)
            0:       return ndf ? 8'h92 : 8'h62;
            1, 2:    return 8'h93;
            3:       return 8'h0A;
            4, 5:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one frame: start pulse in its own cycle (or with slot 0 when overlap), then nine slots
    task automatic run_frame(input bit line, input bit path, input bit overlap,
                             input bit mid_flip, input string req);
        line_ais_req = line;
        path_ais_req = path;
        frame_start  = 1'b1;
        exp_ndf = exp_ais & ~(line | path);
        exp_ais = line | path;
        if (!overlap) begin
            slot_valid = 1'b0;
            @(negedge clk);
            frame_start = 1'b0;
        end
        for (int i = 0; i < 9; i++) begin
            slot_valid = 1'b1;
            slot_idx   = 4'(i);
            @(negedge clk);
            frame_start = 1'b0;
            check(req, {out_valid, out_byte}, {1'b1, exp_byte(i, exp_ais, exp_ndf)});
            if (mid_flip && i == 3) begin
                line_ais_req = ~line_ais_req;
                path_ais_req = $urandom_range(0, 1);
            end
        end
        slot_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; frame_start = 1'b0; slot_valid = 1'b0; slot_idx = '0;
        line_ais_req = 1'b0; path_ais_req = 1'b0;
        exp_ais = 1'b1; exp_ndf = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {out_valid, out_byte}, 9'h000);
        rst = 1'b0;
        // before any frame start the state is forced (R1)
        slot_valid = 1'b1; slot_idx = 4'd0;
        @(negedge clk);
        check("R1 pre-frame", {out_valid, out_byte}, 9'h1FF);
        slot_valid = 1'b0;
        @(negedge clk);

        run_frame(0, 0, 0, 0, "R1 R6 first frame flag");
        run_frame(0, 0, 0, 0, "R2 R3 R4 normal");
        run_frame(1, 0, 0, 0, "R5 line alarm");
        run_frame(0, 1, 0, 0, "R5 path alarm");
        run_frame(1, 1, 0, 0, "R5 both alarms");
        run_frame(0, 0, 0, 0, "R6 flag after clear");
        run_frame(0, 0, 0, 0, "R6 flag gone");
        run_frame(0, 0, 0, 1, "R7 mid-frame change ignored");
        run_frame(1, 0, 1, 0, "R7 overlap start");
        run_frame(0, 0, 1, 1, "R7 overlap clear");

        // R8: latency and out-of-range indices
        for (int k = 9; k < 16; k++) begin
            slot_valid = 1'b1; slot_idx = 4'(k);
            @(negedge clk);
            check("R8 out of range", {8'h00, out_valid}, 9'h000);
        end
        slot_valid = 1'b0; slot_idx = 4'd3;
        @(negedge clk);
        check("R8 no request", {8'h00, out_valid}, 9'h000);

        for (int f = 0; f < 80; f++) begin
            bit l = ($urandom_range(0, 3) == 0);
            bit p = ($urandom_range(0, 3) == 0);
            run_frame(l, p, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                      "R2 R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule